// File: doc/BRIEF.md
# Status channel frame generator

This block drives a two-bit flow-control status bus, one word per clock, towards the transmit side of a packet interface. A frame opens with a framing word. Then comes a run of status words whose order is set by a calendar table: each calendar entry names a port, and the word sent in that slot is that port's two-bit status. The whole calendar is replayed a programmable number of times. The frame then closes with a two-bit diagonal parity (DIP2) check word that covers every status word of the frame.

The sequencer is a three-state machine. ST_FRAME drives the framing word and captures the calendar length and repetition count. ST_SLOT drives one calendar entry per cycle. ST_CHECK drives the parity word. The transitions are:

- FRAME_TO_SLOT: leaving framing when the out-of-frame input is low.
- SLOT_WRAP: staying in ST_SLOT and restarting the slot at 1 for the next repetition.
- SLOT_TO_CHECK: leaving after the last slot of the last repetition.
- CHECK_TO_FRAME: the check word is always followed by framing.
- RESYNC: from any state to ST_FRAME while out-of-frame is high.

The output is decoded from the state alone, with no extra register. An error-injection input lets a bench corrupt the parity on purpose to exercise a receiver's parity checking.

Top module: `status_frame_gen`

## Requirements
- R1: While `oof` is high at a rising clock edge, `status_out` equals the framing word 2'b11 during the following cycle.
- R2: After `oof` falls, the framing word stays on the bus for one more cycle. The next frame then starts fresh: slot 1, repetition 1, parity accumulator cleared.
- R3: The word in slot k (1-based) is `port_status[2*p+1:2*p]`, where p is calendar entry k-1, held in `calendar[PORT_W*(k-1) +: PORT_W]`.
- R4: A frame carries exactly L*M status words between its framing word and its check word, where L is the effective calendar length and M is the effective repetition count. The slot restarts at 1 at each repetition.
- R5: The accumulator is 2'b00 during the first status word. After each status word w it becomes w XOR {acc[0], acc[1]}.
- R6: The check word is {~acc[0], ~acc[1]}, computed from the accumulator after the last status word.
- R7: The cycle after the check word always carries the framing word, and a new frame follows.
- R8: `cal_len` and `cal_m` are sampled only when leaving the framing word. Changing them during a frame changes neither that frame's length nor its parity.
- R9: A length of 0 acts as 1, and a length above CAL_DEPTH acts as CAL_DEPTH. A repetition count of 0 acts as 1, and a count above MAX_REP acts as MAX_REP.
- R10: When `err_inject` is high during the check word cycle, both bits of the check word are inverted. Status words and framing words are unaffected.
- R11: While `rst_n` is low, the bus shows the framing word. The first frame after reset starts with a fresh accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oof | input | 1 | Out-of-frame: force framing and restart |
| cal_len | input | LEN_W | Calendar length request |
| cal_m | input | REP_W | Calendar repetition request |
| err_inject | input | 1 | Invert the check word of the current frame |
| calendar | input | CAL_DEPTH*PORT_W | Slot-to-port table, entry i at bits [PORT_W*i +: PORT_W] |
| port_status | input | NUM_PORTS*2 | Two status bits per port, port p at bits [2p+1:2p] |
| status_out | output | 2 | Status bus |

## Verification
The bench sweeps every length and repetition count of a small configuration. It rebuilds each expected frame and its parity arithmetically, so a design that updates the accumulator without swapping its bits, or forgets to invert the check word, is caught on the first multi-word frame. Out-of-range length and repetition codes are driven to catch a clamp that lets the slot counter run past the table, which would give a wrong frame length. The length is changed mid-frame to catch a design that reads the live input and truncates or stretches the frame. Out-of-frame is raised mid-frame to catch a design that resumes with a stale slot counter or accumulator and so produces a wrong check word.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
    typedef enum logic [1:0] {
        ST_FRAME = 2'd0,
        ST_SLOT  = 2'd1,
        ST_CHECK = 2'd2
    } sfg_state_e;

    localparam logic [1:0] FRAME_WORD = 2'b11;

    function automatic logic [1:0] swap2(input logic [1:0] v);
        return {v[0], v[1]};
    endfunction
endpackage

// File: rtl/sfg_seq.sv
module sfg_seq
    import sfg_pkg::*;
#(
    parameter int CAL_DEPTH = 8,
    parameter int MAX_REP   = 4,
    parameter int LEN_W     = $clog2(CAL_DEPTH + 1),
    parameter int REP_W     = $clog2(MAX_REP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oof,
    input  logic [LEN_W-1:0] cal_len,
    input  logic [REP_W-1:0] cal_m,
    output sfg_state_e       state,
    output logic [LEN_W-1:0] slot,
    output logic [REP_W-1:0] rep,
    output logic [LEN_W-1:0] len_q,
    output logic [REP_W-1:0] m_q
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(CAL_DEPTH);
    localparam logic [REP_W-1:0] REP_MAX = REP_W'(MAX_REP);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [REP_W-1:0] REP_ONE = REP_W'(1);

    sfg_state_e       state_n;
    logic [LEN_W-1:0] slot_n, len_n, len_c;
    logic [REP_W-1:0] rep_n, m_n, m_c;

    // Clamp requested length and repetition count into legal range
    always_comb begin
        if (cal_len == '0)          len_c = LEN_ONE;
        else if (cal_len > LEN_MAX) len_c = LEN_MAX;
        else                        len_c = cal_len;
        if (cal_m == '0)            m_c = REP_ONE;
        else if (cal_m > REP_MAX)   m_c = REP_MAX;
        else                        m_c = cal_m;
    end

    always_comb begin
        state_n = state;
        slot_n  = slot;
        rep_n   = rep;
        len_n   = len_q;
        m_n     = m_q;
        if (oof) begin
            // RESYNC
            state_n = ST_FRAME;
            slot_n  = LEN_ONE;
            rep_n   = REP_ONE;
        end else begin
            unique case (state)
                ST_FRAME: begin
                    // FRAME_TO_SLOT: configuration captured here only
                    len_n   = len_c;
                    m_n     = m_c;
                    slot_n  = LEN_ONE;
                    rep_n   = REP_ONE;
                    state_n = ST_SLOT;
                end
                ST_SLOT: begin
                    if (slot == len_q) begin
                        if (rep == m_q) begin
                            state_n = ST_CHECK;      // SLOT_TO_CHECK
                        end else begin
                            slot_n = LEN_ONE;        // SLOT_WRAP
                            rep_n  = rep + REP_ONE;
                        end
                    end else begin
                        slot_n = slot + LEN_ONE;
                    end
                end
                ST_CHECK: begin
                    state_n = ST_FRAME;              // CHECK_TO_FRAME
                    slot_n  = LEN_ONE;
                    rep_n   = REP_ONE;
                end
                default: state_n = ST_FRAME;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FRAME;
            slot  <= LEN_ONE;
            rep   <= REP_ONE;
            len_q <= LEN_ONE;
            m_q   <= REP_ONE;
        end else begin
            state <= state_n;
            slot  <= slot_n;
            rep   <= rep_n;
            len_q <= len_n;
            m_q   <= m_n;
        end
    end
endmodule

// File: rtl/sfg_slot_mux.sv
module sfg_slot_mux #(
    parameter int CAL_DEPTH = 8,
    parameter int NUM_PORTS = 8,
    parameter int PORT_W    = 3,
    parameter int LEN_W     = 4
) (
    input  logic [LEN_W-1:0]            slot,
    input  logic [CAL_DEPTH*PORT_W-1:0] calendar,
    input  logic [NUM_PORTS*2-1:0]      port_status,
    output logic [1:0]                  word
);
    logic [PORT_W-1:0] cal_arr [CAL_DEPTH];
    logic [1:0]        st_arr  [NUM_PORTS];
    logic [PORT_W-1:0] pidx;

    genvar g;
    generate
        for (g = 0; g < CAL_DEPTH; g++) begin : g_cal
            assign cal_arr[g] = calendar[g*PORT_W +: PORT_W];
        end
        for (g = 0; g < NUM_PORTS; g++) begin : g_st
            assign st_arr[g] = port_status[g*2 +: 2];
        end
    endgenerate

    // Slot k reads calendar entry k-1
    always_comb begin
        pidx = '0;
        for (int i = 0; i < CAL_DEPTH; i++)
            if (slot == LEN_W'(i + 1)) pidx = cal_arr[i];
    end

    always_comb begin
        word = 2'b00;
        for (int p = 0; p < NUM_PORTS; p++)
            if (pidx == PORT_W'(p)) word = st_arr[p];
    end
endmodule

// File: rtl/sfg_dip2.sv
module sfg_dip2
    import sfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oof,
    input  sfg_state_e state,
    input  logic [1:0] word,
    output logic [1:0] acc,
    output logic [1:0] chk_word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= 2'b00;
        else if (oof || state == ST_FRAME)
            acc <= 2'b00;
        else if (state == ST_SLOT)
            acc <= word ^ swap2(acc);
    end

    assign chk_word = ~swap2(acc);
endmodule

// File: rtl/status_frame_gen.sv
module status_frame_gen
    import sfg_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int PORT_W    = $clog2(NUM_PORTS),
    parameter int CAL_DEPTH = 8,
    parameter int MAX_REP   = 4,
    parameter int LEN_W     = $clog2(CAL_DEPTH + 1),
    parameter int REP_W     = $clog2(MAX_REP + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        oof,
    input  logic [LEN_W-1:0]            cal_len,
    input  logic [REP_W-1:0]            cal_m,
    input  logic                        err_inject,
    input  logic [CAL_DEPTH*PORT_W-1:0] calendar,
    input  logic [NUM_PORTS*2-1:0]      port_status,
    output logic [1:0]                  status_out
);
    sfg_state_e       state;
    logic [LEN_W-1:0] slot, len_q;
    logic [REP_W-1:0] rep, m_q;
    logic [1:0]       word, acc, chk_word;

    sfg_seq #(
        .CAL_DEPTH(CAL_DEPTH), .MAX_REP(MAX_REP),
        .LEN_W(LEN_W), .REP_W(REP_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .oof(oof),
        .cal_len(cal_len), .cal_m(cal_m),
        .state(state), .slot(slot), .rep(rep),
        .len_q(len_q), .m_q(m_q)
    );

    sfg_slot_mux #(
        .CAL_DEPTH(CAL_DEPTH), .NUM_PORTS(NUM_PORTS),
        .PORT_W(PORT_W), .LEN_W(LEN_W)
    ) u_mux (
        .slot(slot), .calendar(calendar),
        .port_status(port_status), .word(word)
    );

    sfg_dip2 u_dip2 (
        .clk(clk), .rst_n(rst_n), .oof(oof), .state(state),
        .word(word), .acc(acc), .chk_word(chk_word)
    );

    always_comb begin
        unique case (state)
            ST_FRAME: status_out = FRAME_WORD;
            ST_SLOT:  status_out = word;
            ST_CHECK: status_out = chk_word ^ {2{err_inject}};
            default:  status_out = FRAME_WORD;
        endcase
    end
endmodule

// File: rtl/sfg_chk.sv
module sfg_chk
    import sfg_pkg::*;
#(
    parameter int CAL_DEPTH = 8,
    parameter int MAX_REP   = 4,
    parameter int LEN_W     = 4,
    parameter int REP_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             oof,
    input logic [1:0]       status_out,
    input sfg_state_e       state,
    input logic [LEN_W-1:0] slot,
    input logic [LEN_W-1:0] len_q,
    input logic [REP_W-1:0] rep,
    input logic [REP_W-1:0] m_q,
    input logic [1:0]       acc
);
    // R1
    oof_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oof |=> (status_out == 2'b11));

    // R7
    check_to_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK) |=> (state == ST_FRAME && status_out == 2'b11));

    // R5
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FRAME) |=> (acc == 2'b00));

    // R4
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOT) |-> (slot >= LEN_W'(1) && slot <= len_q
                                && rep >= REP_W'(1) && rep <= m_q));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FRAME) |=> ($stable(len_q) && $stable(m_q)));

    // R9
    cfg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q >= LEN_W'(1) && len_q <= LEN_W'(CAL_DEPTH)
         && m_q >= REP_W'(1) && m_q <= REP_W'(MAX_REP)));
endmodule

bind status_frame_gen sfg_chk #(
    .CAL_DEPTH(CAL_DEPTH), .MAX_REP(MAX_REP),
    .LEN_W(LEN_W), .REP_W(REP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .oof(oof), .status_out(status_out),
    .state(state), .slot(slot), .len_q(len_q), .rep(rep),
    .m_q(m_q), .acc(acc)
);

// File: tb/tb_status_frame_gen.sv
module tb_status_frame_gen;
    localparam int NP = 8;
    localparam int PW = 3;
    localparam int CD = 8;
    localparam int MR = 4;
    localparam int LW = 4;
    localparam int RW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              oof = 1'b0;
    logic [LW-1:0]     cal_len = '0;
    logic [RW-1:0]     cal_m = '0;
    logic              err_inject = 1'b0;
    logic [CD*PW-1:0]  calendar = '0;
    logic [NP*2-1:0]   port_status = '0;
    logic [1:0]        status_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [PW-1:0] cal_tb [CD];
    logic [1:0]    st_tb  [NP];

    status_frame_gen #(
        .NUM_PORTS(NP), .PORT_W(PW), .CAL_DEPTH(CD), .MAX_REP(MR),
        .LEN_W(LW), .REP_W(RW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .oof(oof), .cal_len(cal_len),
        .cal_m(cal_m), .err_inject(err_inject), .calendar(calendar),
        .port_status(port_status), .status_out(status_out)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic load_tables(input int seed);
        for (int k = 0; k < CD; k++) begin
            cal_tb[k] = PW'((k * 5 + seed) % NP);
            calendar[k*PW +: PW] = cal_tb[k];
        end
        for (int p = 0; p < NP; p++) begin
            st_tb[p] = 2'((p * 3 + seed + p / 2) % 4);
            port_status[p*2 +: 2] = st_tb[p];
        end
    endtask

    function automatic int clampi(input int v, input int hi);
        if (v == 0) return 1;
        if (v > hi) return hi;
        return v;
    endfunction

    // Entered at a negedge where the framing word should be on the bus.
    task automatic run_frame(input int raw_len, input int raw_m,
                             input bit inj, input bit chg);
        int l = clampi(raw_len, CD);
        int m = clampi(raw_m, MR);
        logic [1:0] acc = 2'b00;
        logic [1:0] w;
        cal_len = LW'(raw_len);
        cal_m   = RW'(raw_m);
        chk("R2/R7 framing before frame", status_out, 2'b11);
        for (int r = 0; r < m; r++) begin
            for (int k = 1; k <= l; k++) begin
                @(negedge clk);
                w = st_tb[cal_tb[k-1]];
                // R3 R4 R9: word order and count
                chk("R3 slot word", status_out, w);
                acc = w ^ {acc[0], acc[1]};
                if (chg && r == 0 && k == 1) begin
                    cal_len = LW'((raw_len % CD) + 1 == l ? (l % CD) + 1 : (raw_len % CD) + 1);
                    cal_m   = RW'((m % MR) + 1);
                end
            end
        end
        err_inject = inj;
        @(negedge clk);
        // R6 R10 R5: parity word
        chk(inj ? "R10 inverted check" : "R6 check word", status_out,
            inj ? {acc[0], acc[1]} : ~{acc[0], acc[1]});
        err_inject = 1'b0;
        cal_len = LW'(raw_len);
        cal_m   = RW'(raw_m);
        @(negedge clk);
        chk("R7 framing after check", status_out, 2'b11);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        load_tables(0);
        repeat (3) @(negedge clk);
        // R11: framing during reset
        chk("R11 reset framing", status_out, 2'b11);
        rst_n = 1'b1;
        run_frame(3, 2, 1'b0, 1'b0);

        // R4 R3 R5 R6: full sweep of length and repetition
        for (int m = 1; m <= MR; m++) begin
            for (int l = 1; l <= CD; l++) begin
                load_tables(l * 7 + m);
                run_frame(l, m, 1'b0, 1'b0);
            end
        end

        // R9: out-of-range codes clamp
        run_frame(0, 0, 1'b0, 1'b0);
        run_frame(15, 7, 1'b0, 1'b0);
        run_frame(9, 1, 1'b0, 1'b0);

        // R8: configuration changed mid-frame has no effect on that frame
        load_tables(5);
        run_frame(5, 2, 1'b0, 1'b1);
        run_frame(2, 3, 1'b0, 1'b1);

        // R10: injected frame, then a clean frame
        run_frame(4, 2, 1'b1, 1'b0);
        run_frame(4, 2, 1'b0, 1'b0);

        // R1 R2: out-of-frame in the middle of a frame
        cal_len = LW'(6);
        cal_m   = RW'(3);
        repeat (4) @(negedge clk);
        oof = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R1 framing while out of frame", status_out, 2'b11);
        end
        oof = 1'b0;
        load_tables(11);
        run_frame(6, 3, 1'b0, 1'b0);

        // R1: out-of-frame right at the check word cycle
        cal_len = LW'(2);
        cal_m   = RW'(1);
        repeat (2) @(negedge clk);
        oof = 1'b1;
        @(negedge clk);
        chk("R1 oof over check slot", status_out, 2'b11);
        oof = 1'b0;
        run_frame(7, 4, 1'b0, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule